// File: doc/BRIEF.md
# Multi-Lane Accumulator Bank with Rounding Readout

This block holds the accumulator state of a packed-vector datapath. The state is 192 bits wide and can be seen in two ways. In byte view it is eight signed 24-bit accumulators, each fed by an unsigned byte lane of the 64-bit operands. In halfword view it is four signed 48-bit accumulators, each fed by a signed 16-bit lane. One command is taken per cycle on a valid strobe. A command can accumulate into every lane, load every lane, write part of each lane from two operand vectors, or read the lanes back. A readout returns either a raw 8- or 16-bit slice of each accumulator or a scaled value. The scaled value is shifted right by a per-lane amount, then rounded by one of six modes and clamped to the lane range.

The second operand has three sources: a full vector, one lane of a vector broadcast to all lanes, or a small unsigned immediate. The scaled readout takes its per-lane shift amounts from that same resolved operand. Readout results and an error flag are registered and stay unchanged until the next readout command.

Top module: `simd_acc_bank`

## Requirements
- R1: While rst_ni is low, every accumulator, result_o and err_o are zero. After release, a raw readout of any slice returns zero.
- R2: With fmt_i=0 and cmd_i=0, sub_i selects the update on every unsigned byte lane A, with B the resolved operand and arithmetic modulo 2^24. The codes are: 0 acc+=A+B, 1 acc=A+B, 2 acc+=A*B, 3 acc=A*B, 4 acc-=A*B, 5 acc=-(A*B), 6 acc+=A-B, 7 acc=A-B. Byte lane j occupies bits 8j+7:8j.
- R3: With fmt_i=1, the same eight update codes apply to four signed 16-bit lanes with 48-bit accumulators, modulo 2^48. Lane i occupies bits 16i+15:16i.
- R4: opb_mode_i selects operand B. Code 0 uses b_i lane by lane, and code 3 does the same. Code 1 broadcasts lane lane_i of b_i, using lane_i[1:0] in halfword view. Code 2 uses imm_i zero-extended to the lane width.
- R5: cmd_i=3 is a raw readout. sub_i=0, 1 or 2 returns bits w*k+w-1:w*k of each accumulator (w=8 or 16, k=sub_i), and sub_i=3 returns zero. The raw readout clears err_o.
- R6: cmd_i=1 sets each accumulator to the a_i lane, sign-extended to twice the lane width and placed above the b_i lane.
- R7: cmd_i=2 replaces only the top w bits of each accumulator with the a_i lane and keeps the lower 2w bits.
- R8: cmd_i=4 with sub_i 1, 3 or 5 reads the accumulator as unsigned. It shifts right by the lane of operand B and rounds: 1 to nearest with ties upward, 3 to nearest with ties to even, 5 by truncation. The value is then clamped to 255 or 65535. A shift equal to the accumulator width rounds on the top bit alone, and a larger shift gives 0.
- R9: In halfword view, sub_i 0, 2 and 4 read the accumulator as signed, shifting arithmetically. Mode 0 rounds ties away from zero, mode 2 rounds ties to even, and mode 4 truncates toward minus infinity. The value is clamped to -32768..32767 by the accumulator sign. A shift of 48 or more gives 0.
- R10: For a signed mode in byte view, or sub_i 6 or 7, every lane of the scaled readout is zero and err_o is 1. For a halfword shift amount with bit 15 set, that lane is zero and err_o is 1. Any other scaled readout leaves err_o at 0.
- R11: result_o and err_o change only one cycle after a valid readout strobe. Readouts, cmd_i 5..7 and idle cycles leave the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_i | input | 3 | 0 update, 1 write low, 2 write high, 3 raw read, 4 scaled read |
| fmt_i | input | 1 | 0 byte view, 1 halfword view |
| sub_i | input | 3 | Update code, slice select or rounding mode |
| opb_mode_i | input | 2 | Operand B source |
| lane_i | input | 3 | Broadcast lane index |
| imm_i | input | 5 | Immediate operand B |
| a_i | input | 64 | Operand A vector |
| b_i | input | 64 | Operand B vector |
| result_o | output | 64 | Registered packed readout |
| err_o | output | 1 | Registered readout error flag |

## Verification
On one clock edge the block can commit an accumulator update while result_o holds an earlier readout. On the very next edge a readout must see the value that update just committed. The bench provokes both by issuing strobes back to back with no idle gap: a readout, then an update, then another readout. It checks that the held result survives the update unchanged and that the next readout reflects the new sum. It also places unused command codes between two readouts, and expects the accumulator value to be identical before and after them.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;
  typedef enum logic [2:0] {
    CMD_ACC  = 3'd0,
    CMD_WRLO = 3'd1,
    CMD_WRHI = 3'd2,
    CMD_RAW  = 3'd3,
    CMD_RND  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    OPB_VEC  = 2'd0,
    OPB_LANE = 2'd1,
    OPB_IMM  = 2'd2
  } opb_e;

  typedef enum logic [2:0] {
    RND_AWAY_S  = 3'd0,
    RND_AWAY_U  = 3'd1,
    RND_EVEN_S  = 3'd2,
    RND_EVEN_U  = 3'd3,
    RND_TRUNC_S = 3'd4,
    RND_TRUNC_U = 3'd5
  } rnd_e;
endpackage

// File: rtl/simd_acc_opb.sv
module simd_acc_opb #(
  parameter int VEC_W = 64,
  parameter int EW    = 8,
  parameter int IMM_W = 5,
  localparam int LN   = VEC_W / EW,
  localparam int LS_W = $clog2(LN)
) (
  input  logic [VEC_W-1:0] b_i,
  input  logic [1:0]       mode_i,
  input  logic [LS_W-1:0]  lane_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [VEC_W-1:0] opb_o
);
  import simd_acc_pkg::*;

  logic [EW-1:0] bcast;
  logic [EW-1:0] imm_ext;

  assign bcast   = b_i[lane_i*EW +: EW];
  assign imm_ext = {{(EW-IMM_W){1'b0}}, imm_i};

  for (genvar i = 0; i < LN; i++) begin : g_el
    always_comb begin
      case (mode_i)
        OPB_LANE: opb_o[i*EW +: EW] = bcast;
        OPB_IMM:  opb_o[i*EW +: EW] = imm_ext;
        default:  opb_o[i*EW +: EW] = b_i[i*EW +: EW];
      endcase
    end
  end
endmodule

// File: rtl/simd_acc_round.sv
module simd_acc_round #(
  parameter int AW        = 24,
  parameter int OW        = 8,
  parameter bit SIGNED_OK = 1'b0,
  localparam int XW       = AW + 2
) (
  input  logic [AW-1:0] acc_i,
  input  logic [OW-1:0] sh_i,
  input  logic [2:0]    mode_i,
  output logic [OW-1:0] res_o,
  output logic          err_o
);
  import simd_acc_pkg::*;

  localparam logic [OW-1:0] AW_S = OW'(AW);
  localparam logic [OW-1:0] ONE_S = OW'(1);
  localparam logic signed [XW-1:0] UMAX_X = XW'((64'd1 << OW) - 64'd1);
  localparam logic signed [XW-1:0] SMAX_X = XW'((64'd1 << (OW - 1)) - 64'd1);
  localparam logic signed [XW-1:0] SMIN_X = -SMAX_X - XW'(1);

  logic                 sgn_mode, even_mode, trunc_mode, bad_mode, neg_sh;
  logic [AW-1:0]        sh_u, half_v, low_mask;
  logic signed [AW-1:0] sh_s;
  logic                 rbit, sticky, inc;
  logic signed [XW-1:0] t, tr, cl;

  always_comb begin
    sgn_mode   = (mode_i == RND_AWAY_S) || (mode_i == RND_EVEN_S) || (mode_i == RND_TRUNC_S);
    even_mode  = (mode_i == RND_EVEN_S) || (mode_i == RND_EVEN_U);
    trunc_mode = (mode_i == RND_TRUNC_S) || (mode_i == RND_TRUNC_U);
    bad_mode   = (mode_i > RND_TRUNC_U) || (sgn_mode && !SIGNED_OK);
    neg_sh     = SIGNED_OK && sh_i[OW-1];

    sh_u     = acc_i >> sh_i;
    sh_s     = $signed(acc_i) >>> sh_i;
    half_v   = acc_i >> (sh_i - ONE_S);
    low_mask = ~({AW{1'b1}} << (sh_i - ONE_S));
    // round bit exists only for 1..AW; sticky covers bits below it
    rbit     = (sh_i != '0) && (sh_i <= AW_S) && half_v[0];
    sticky   = (sh_i > ONE_S) && (|(acc_i & low_mask));

    t = sgn_mode ? {{2{sh_s[AW-1]}}, sh_s} : {2'b00, sh_u};

    if (trunc_mode)                   inc = 1'b0;
    else if (even_mode)               inc = rbit && (sticky || t[0]);
    else if (sgn_mode && acc_i[AW-1]) inc = rbit && sticky;
    else                              inc = rbit;

    tr = t + {{(XW-1){1'b0}}, inc};

    if (sgn_mode) begin
      if (acc_i[AW-1]) cl = (tr < SMIN_X) ? SMIN_X : tr;
      else             cl = (tr > SMAX_X) ? SMAX_X : tr;
    end else begin
      cl = (tr > UMAX_X) ? UMAX_X : tr;
    end

    if (bad_mode || neg_sh || (sgn_mode && (sh_i >= AW_S))) res_o = '0;
    else                                                  res_o = cl[OW-1:0];
    err_o = bad_mode || neg_sh;
  end
endmodule

// File: rtl/simd_acc_lane.sv
module simd_acc_lane #(
  parameter int EW        = 8,
  parameter bit SIGNED_OK = 1'b0,
  localparam int AW       = 3 * EW
) (
  input  logic [2:0]    cmd_i,
  input  logic [2:0]    sub_i,
  input  logic [AW-1:0] acc_q_i,
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [EW-1:0] opb_i,
  output logic [AW-1:0] acc_d_o,
  output logic [EW-1:0] raw_o,
  output logic [EW-1:0] rnd_o,
  output logic          rnd_err_o
);
  import simd_acc_pkg::*;

  logic            fill_a, fill_b, fill_p;
  logic [AW-1:0]   ea, eb, sum, diff, prod;
  logic [2*EW-1:0] p2;

  assign fill_a = SIGNED_OK && a_i[EW-1];
  assign fill_b = SIGNED_OK && opb_i[EW-1];
  assign ea     = {{(AW-EW){fill_a}}, a_i};
  assign eb     = {{(AW-EW){fill_b}}, opb_i};
  assign sum    = ea + eb;
  assign diff   = ea - eb;
  // narrow multiply, then widen
  assign p2     = {{EW{fill_a}}, a_i} * {{EW{fill_b}}, opb_i};
  assign fill_p = SIGNED_OK && p2[2*EW-1];
  assign prod   = {{(AW-2*EW){fill_p}}, p2};

  always_comb begin
    acc_d_o = acc_q_i;
    case (cmd_i)
      CMD_ACC: begin
        case (sub_i)
          3'd0:    acc_d_o = acc_q_i + sum;
          3'd1:    acc_d_o = sum;
          3'd2:    acc_d_o = acc_q_i + prod;
          3'd3:    acc_d_o = prod;
          3'd4:    acc_d_o = acc_q_i - prod;
          3'd5:    acc_d_o = -prod;
          3'd6:    acc_d_o = acc_q_i + diff;
          default: acc_d_o = diff;
        endcase
      end
      CMD_WRLO: acc_d_o = {{EW{a_i[EW-1]}}, a_i, b_i};
      CMD_WRHI: acc_d_o = {a_i, acc_q_i[2*EW-1:0]};
      default:  acc_d_o = acc_q_i;
    endcase
  end

  always_comb begin
    case (sub_i)
      3'd0:    raw_o = acc_q_i[EW-1:0];
      3'd1:    raw_o = acc_q_i[2*EW-1:EW];
      3'd2:    raw_o = acc_q_i[3*EW-1:2*EW];
      default: raw_o = '0;
    endcase
  end

  simd_acc_round #(
    .AW(AW),
    .OW(EW),
    .SIGNED_OK(SIGNED_OK)
  ) u_round (
    .acc_i (acc_q_i),
    .sh_i  (opb_i),
    .mode_i(sub_i),
    .res_o (rnd_o),
    .err_o (rnd_err_o)
  );
endmodule

// File: rtl/simd_acc_bank.sv
module simd_acc_bank #(
  parameter int VEC_W  = 64,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  parameter int IMM_W  = 5,
  localparam int NB    = VEC_W / BYTE_W,
  localparam int NH    = VEC_W / HALF_W,
  localparam int BA_W  = 3 * BYTE_W,
  localparam int HA_W  = 3 * HALF_W,
  localparam int ACC_BITS = NB * BA_W,
  localparam int LB_W  = $clog2(NB),
  localparam int LH_W  = $clog2(NH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              fmt_i,
  input  logic [2:0]        sub_i,
  input  logic [1:0]        opb_mode_i,
  input  logic [LB_W-1:0]   lane_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  output logic [VEC_W-1:0]  result_o,
  output logic              err_o
);
  import simd_acc_pkg::*;

  logic [ACC_BITS-1:0] acc_q, byte_next, half_next, acc_next;
  logic [VEC_W-1:0]    opb_b, opb_h;
  logic [VEC_W-1:0]    byte_raw, byte_rnd, half_raw, half_rnd;
  logic [NB-1:0]       byte_err;
  logic [NH-1:0]       half_err;
  logic                mutate, rd_raw, rd_rnd;

  simd_acc_opb #(.VEC_W(VEC_W), .EW(BYTE_W), .IMM_W(IMM_W)) u_opb_b (
    .b_i(b_i), .mode_i(opb_mode_i), .lane_i(lane_i), .imm_i(imm_i), .opb_o(opb_b)
  );

  simd_acc_opb #(.VEC_W(VEC_W), .EW(HALF_W), .IMM_W(IMM_W)) u_opb_h (
    .b_i(b_i), .mode_i(opb_mode_i), .lane_i(lane_i[LH_W-1:0]), .imm_i(imm_i), .opb_o(opb_h)
  );

  for (genvar j = 0; j < NB; j++) begin : g_byte
    simd_acc_lane #(.EW(BYTE_W), .SIGNED_OK(1'b0)) u_lane (
      .cmd_i    (cmd_i),
      .sub_i    (sub_i),
      .acc_q_i  (acc_q[j*BA_W +: BA_W]),
      .a_i      (a_i[j*BYTE_W +: BYTE_W]),
      .b_i      (b_i[j*BYTE_W +: BYTE_W]),
      .opb_i    (opb_b[j*BYTE_W +: BYTE_W]),
      .acc_d_o  (byte_next[j*BA_W +: BA_W]),
      .raw_o    (byte_raw[j*BYTE_W +: BYTE_W]),
      .rnd_o    (byte_rnd[j*BYTE_W +: BYTE_W]),
      .rnd_err_o(byte_err[j])
    );

    AST_BYTE_WRHI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && cmd_i == CMD_WRHI && !fmt_i)
      |=> acc_q[j*BA_W +: 2*BYTE_W] == $past(acc_q[j*BA_W +: 2*BYTE_W])); // R7
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_acc_lane #(.EW(HALF_W), .SIGNED_OK(1'b1)) u_lane (
      .cmd_i    (cmd_i),
      .sub_i    (sub_i),
      .acc_q_i  (acc_q[i*HA_W +: HA_W]),
      .a_i      (a_i[i*HALF_W +: HALF_W]),
      .b_i      (b_i[i*HALF_W +: HALF_W]),
      .opb_i    (opb_h[i*HALF_W +: HALF_W]),
      .acc_d_o  (half_next[i*HA_W +: HA_W]),
      .raw_o    (half_raw[i*HALF_W +: HALF_W]),
      .rnd_o    (half_rnd[i*HALF_W +: HALF_W]),
      .rnd_err_o(half_err[i])
    );

    AST_HALF_WRHI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && cmd_i == CMD_WRHI && fmt_i)
      |=> acc_q[i*HA_W +: 2*HALF_W] == $past(acc_q[i*HA_W +: 2*HALF_W])); // R7
  end

  assign mutate   = (cmd_i == CMD_ACC) || (cmd_i == CMD_WRLO) || (cmd_i == CMD_WRHI);
  assign rd_raw   = (cmd_i == CMD_RAW);
  assign rd_rnd   = (cmd_i == CMD_RND);
  assign acc_next = fmt_i ? half_next : byte_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else if (valid_i) begin
      if (mutate) acc_q <= acc_next;
      if (rd_raw) begin
        result_o <= fmt_i ? half_raw : byte_raw;
        err_o    <= 1'b0;
      end else if (rd_rnd) begin
        result_o <= fmt_i ? half_rnd : byte_rnd;
        err_o    <= fmt_i ? |half_err : |byte_err;
      end
    end
  end

  AST_ERR_FROM_RND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(valid_i && cmd_i == CMD_RND)); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || (cmd_i != CMD_RAW && cmd_i != CMD_RND))
    |=> ($stable(result_o) && $stable(err_o))); // R11

  AST_ACC_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (cmd_i == CMD_RAW || cmd_i == CMD_RND)) |=> $stable(acc_q)); // R11

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q)); // R11
endmodule

// File: tb/simd_acc_bank_test.sv
module simd_acc_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic        fmt_i = 1'b0;
  logic [2:0]  sub_i = '0;
  logic [1:0]  opb_mode_i = '0;
  logic [2:0]  lane_i = '0;
  logic [4:0]  imm_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        err_o;

  int n_chk = 0;
  int n_fail = 0;

  simd_acc_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cmd_i(cmd_i), .fmt_i(fmt_i),
    .sub_i(sub_i), .opb_mode_i(opb_mode_i), .lane_i(lane_i), .imm_i(imm_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .err_o(err_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [63:0] r8(input logic [7:0] v);
    return {8{v}};
  endfunction

  function automatic logic [63:0] r16(input logic [15:0] v);
    return {4{v}};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // drive one strobe at a falling edge; output visible at the next falling edge
  task automatic drive(input logic [2:0] c, input logic f, input logic [2:0] s,
                       input logic [1:0] om, input logic [2:0] ln, input logic [4:0] im,
                       input logic [63:0] a, input logic [63:0] b);
    valid_i = 1'b1; cmd_i = c; fmt_i = f; sub_i = s; opb_mode_i = om;
    lane_i = ln; imm_i = im; a_i = a; b_i = b;
    @(negedge clk_i);
  endtask

  task automatic idle;
    valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic op(input logic [2:0] c, input logic f, input logic [2:0] s,
                    input logic [1:0] om, input logic [2:0] ln, input logic [4:0] im,
                    input logic [63:0] a, input logic [63:0] b);
    drive(c, f, s, om, ln, im, a, b);
    idle();
  endtask

  task automatic raw(input logic f, input logic [2:0] sel, input logic [63:0] exp, input string tag);
    drive(3'd3, f, sel, 2'd0, 3'd0, 5'd0, '0, '0);
    chk(tag, result_o, exp);
    idle();
  endtask

  task automatic rnd(input logic f, input logic [2:0] m, input logic [1:0] om, input logic [4:0] im,
                     input logic [63:0] b, input logic [63:0] exp, input logic exp_err, input string tag);
    drive(3'd4, f, m, om, 3'd0, im, '0, b);
    chk(tag, result_o, exp);
    chk({tag, " err"}, {63'd0, err_o}, {63'd0, exp_err});
    idle();
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk("R1 result in reset", result_o, '0);
    chk("R1 err in reset", {63'd0, err_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    raw(1'b0, 3'd0, '0, "R1 byte low after reset");
    raw(1'b1, 3'd2, '0, "R1 half high after reset");
  endtask

  task automatic t_byte_acc;
    op(3'd0, 1'b0, 3'd1, 2'd0, 3'd0, 5'd0, 64'h0102030405060708, r8(8'h10));
    raw(1'b0, 3'd0, 64'h1112131415161718, "R2 byte load sum");
    op(3'd0, 1'b0, 3'd2, 2'd2, 3'd0, 5'd5, r8(8'hFF), '0);
    raw(1'b0, 3'd1, r8(8'h05), "R4 imm mac mid slice");
    raw(1'b0, 3'd0, 64'h0C0D0E0F10111213, "R4 imm mac low slice");
  endtask

  task automatic t_byte_signs;
    op(3'd0, 1'b0, 3'd5, 2'd0, 3'd0, 5'd0, r8(8'h02), r8(8'h03));
    raw(1'b0, 3'd2, r8(8'hFF), "R2 negated product high");
    raw(1'b0, 3'd0, r8(8'hFA), "R2 negated product low");
    op(3'd0, 1'b0, 3'd7, 2'd0, 3'd0, 5'd0, r8(8'h01), r8(8'h02));
    op(3'd0, 1'b0, 3'd6, 2'd0, 3'd0, 5'd0, r8(8'h05), r8(8'h01));
    raw(1'b0, 3'd0, r8(8'h03), "R2 load diff then add diff low");
    raw(1'b0, 3'd2, r8(8'h00), "R2 load diff then add diff high");
    op(3'd0, 1'b0, 3'd4, 2'd0, 3'd0, 5'd0, r8(8'h01), r8(8'h04));
    raw(1'b0, 3'd2, r8(8'hFF), "R2 sub product high");
    op(3'd0, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h01), r8(8'h01));
    raw(1'b0, 3'd0, r8(8'h01), "R2 add sum low");
  endtask

  task automatic t_half_acc;
    op(3'd0, 1'b1, 3'd3, 2'd0, 3'd0, 5'd0, r16(16'h8000), r16(16'h8000));
    raw(1'b1, 3'd1, r16(16'h4000), "R3 signed product mid");
    raw(1'b1, 3'd2, r16(16'h0000), "R3 signed product high");
    op(3'd0, 1'b1, 3'd4, 2'd1, 3'd2, 5'd0, r16(16'h7FFF), 64'h0000_0002_0000_0000);
    raw(1'b1, 3'd1, r16(16'h3FFF), "R4 broadcast sub product mid");
    raw(1'b1, 3'd0, r16(16'h0002), "R4 broadcast sub product low");
    raw(1'b1, 3'd3, '0, "R5 select 3 zero");
  endtask

  task automatic t_writes;
    op(3'd1, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, r16(16'hFFFE), r16(16'h1234));
    raw(1'b1, 3'd2, r16(16'hFFFF), "R6 half write low sign");
    raw(1'b1, 3'd1, r16(16'hFFFE), "R6 half write low mid");
    raw(1'b1, 3'd0, r16(16'h1234), "R6 half write low low");
    op(3'd2, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, r16(16'h00AB), '0);
    raw(1'b1, 3'd2, r16(16'h00AB), "R7 half write high top");
    raw(1'b1, 3'd1, r16(16'hFFFE), "R7 half write high keeps mid");
    op(3'd1, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h80), r8(8'h11));
    raw(1'b0, 3'd2, r8(8'hFF), "R6 byte write low sign");
    raw(1'b0, 3'd1, r8(8'h80), "R6 byte write low mid");
    op(3'd2, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h3C), '0);
    raw(1'b0, 3'd2, r8(8'h3C), "R7 byte write high top");
    raw(1'b0, 3'd0, r8(8'h11), "R7 byte write high keeps low");
  endtask

  task automatic t_round_u;
    op(3'd1, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h01), r8(8'h28));
    rnd(1'b0, 3'd1, 2'd2, 5'd4, '0, r8(8'h13), 1'b0, "R8 byte tie away");
    rnd(1'b0, 3'd3, 2'd2, 5'd4, '0, r8(8'h12), 1'b0, "R8 byte tie even");
    rnd(1'b0, 3'd5, 2'd2, 5'd4, '0, r8(8'h12), 1'b0, "R8 byte truncate");
    op(3'd1, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h00), r8(8'h01));
    op(3'd2, 1'b0, 3'd0, 2'd0, 3'd0, 5'd0, r8(8'h80), '0);
    rnd(1'b0, 3'd1, 2'd0, 5'd0, 64'h0000_0000_0000_1918, 64'hFFFF_FFFF_FFFF_0001, 1'b0, "R8 byte width shift away");
    rnd(1'b0, 3'd3, 2'd0, 5'd0, 64'h0000_0000_0000_1918, 64'hFFFF_FFFF_FFFF_0001, 1'b0, "R8 byte width shift even");
    rnd(1'b0, 3'd5, 2'd0, 5'd0, 64'h0000_0000_0000_1918, 64'hFFFF_FFFF_FFFF_0000, 1'b0, "R8 byte width shift trunc");
  endtask

  task automatic t_round_s;
    op(3'd1, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, 64'h0000_0000_FFFF_FFFF, 64'h0028_0028_FFD8_FFD8);
    rnd(1'b1, 3'd0, 2'd2, 5'd4, '0, 64'h0003_0003_FFFD_FFFD, 1'b0, "R9 signed tie away");
    rnd(1'b1, 3'd2, 2'd2, 5'd4, '0, 64'h0002_0002_FFFE_FFFE, 1'b0, "R9 signed tie even");
    rnd(1'b1, 3'd4, 2'd2, 5'd4, '0, 64'h0002_0002_FFFD_FFFD, 1'b0, "R9 signed truncate");
    op(3'd1, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, '0, '0);
    op(3'd2, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, 64'hFFFF_FFFF_0001_0001, '0);
    rnd(1'b1, 3'd0, 2'd0, 5'd0, 64'h0030_0000_0000_0000, 64'h0000_8000_7FFF_7FFF, 1'b0, "R9 signed clamp and wide shift");
    rnd(1'b1, 3'd5, 2'd0, 5'd0, 64'h0030_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 1'b0, "R8 half unsigned clamp");
    rnd(1'b1, 3'd1, 2'd0, 5'd0, 64'h0030_0000_0000_0000, 64'h0001_FFFF_FFFF_FFFF, 1'b0, "R8 half width shift away");
  endtask

  task automatic t_errors;
    rnd(1'b1, 3'd5, 2'd0, 5'd0, 64'h0030_0000_0000_FFFF, 64'h0000_FFFF_FFFF_0000, 1'b1, "R10 negative shift lane");
    rnd(1'b1, 3'd6, 2'd2, 5'd0, '0, '0, 1'b1, "R10 undefined mode");
    raw(1'b1, 3'd0, '0, "R5 raw after error");
    chk("R5 raw clears err", {63'd0, err_o}, '0);
    drive(3'd4, 1'b0, 3'd0, 2'd2, 3'd0, 5'd1, '0, '0);
    chk("R10 signed mode in byte view", result_o, '0);
    chk("R10 signed mode in byte view err", {63'd0, err_o}, 64'd1);
    idle();
  endtask

  task automatic t_hold;
    op(3'd1, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, '0, r16(16'h0005));
    drive(3'd3, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, '0, '0);
    chk("R11 readout before update", result_o, r16(16'h0005));
    drive(3'd0, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, r16(16'h0001), r16(16'h0001));
    chk("R11 result held across update", result_o, r16(16'h0005));
    drive(3'd3, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, '0, '0);
    chk("R11 back-to-back readout sees update", result_o, r16(16'h0007));
    drive(3'd5, 1'b1, 3'd1, 2'd0, 3'd0, 5'd0, r16(16'h1111), r16(16'h2222));
    drive(3'd7, 1'b1, 3'd1, 2'd0, 3'd0, 5'd0, r16(16'h1111), r16(16'h2222));
    chk("R11 unused commands hold result", result_o, r16(16'h0007));
    drive(3'd3, 1'b1, 3'd0, 2'd0, 3'd0, 5'd0, '0, '0);
    chk("R11 unused commands leave state", result_o, r16(16'h0007));
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_byte_acc();
    t_byte_signs();
    t_half_acc();
    t_writes();
    t_round_u();
    t_round_s();
    t_errors();
    t_hold();
    report();
  end
endmodule